// File: doc/BRIEF.md
# Multi-Source Reset Release Sequencer

This block merges every reset request of a chip into one internal system reset and keeps that reset asserted until a fixed release sequence has finished. The requests are a power-on level, an external reset pin that is already synchronized, a one-cycle watchdog pulse, and the deep (second-stage) output of a brown-out comparator. Once no request is present and the oscillator reports itself stable, the sequencer counts a parameterized number of clocks. It then sends a one-cycle start pulse to the flash controller and waits for that controller's done level. Only after the done level is seen does the system reset drop.

A shallow (first-stage) brown-out output never resets the chip. It drives a raw status bit and an interrupt line that is gated by a software-written enable bit. A sticky cause register records which sources have requested reset since software last cleared it. Software clears it with write-one-to-clear accesses. The power-on level is the block's own asynchronous reset. All request, status and register pins are plain levels or strobes. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `rstseq_top`

## Requirements
- R1: While `por_req` is high, `sys_rst` is 1, `flash_init_start` is 0, `bod_irq_en` is 0 and `rst_cause` is 4'b0001, without waiting for a clock edge.
- R2: While `ext_rst_req` is high, `sys_rst` is 1 from the next clock edge onward and no flash start pulse occurs. After it falls, with the oscillator stable, the start pulse appears RELEASE_CYCLES+1 edges later.
- R3: Counting begins on the first edge that finds no request and `osc_stable` high. The counter spans RELEASE_CYCLES edges, and `flash_init_start` is high for exactly one cycle, after the next edge.
- R4: After the start pulse, `sys_rst` falls on the first edge that finds `flash_init_done` high, but never sooner than two edges after the pulse appears. While done stays low, reset stays high.
- R5: A watchdog pulse in any state, including while waiting for flash or while running, raises `sys_rst` on the next edge and restarts the whole sequence. The start pulse follows RELEASE_CYCLES+1 edges after the edge that sees the watchdog pulse.
- R6: If `osc_stable` is low on an edge during counting, the count is abandoned. Counting restarts from zero once the flag returns.
- R7: `bod_status` always mirrors `bod_warn`. `bod_irq` equals `bod_warn` AND `bod_irq_en`. Neither input affects `sys_rst`.
- R8: While `bod_crit` is high, `sys_rst` is held high from the next edge, whatever the oscillator and flash inputs do. Release resumes the normal sequence after it falls.
- R9: `rst_cause` bit 0 is power-on, bit 1 is the external pin, bit 2 is the watchdog and bit 3 is the deep brown-out. A request sets its bit on the edge that sees it, and the bit stays set.
- R10: A strobe on `cause_clr_we` clears each `rst_cause` bit whose `cause_clr_mask` bit is 1 and leaves the others unchanged. A request on the same edge wins over the clear.
- R11: A strobe on `bod_irq_en_we` loads `bod_irq_en` from `bod_irq_en_wdata` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on reset level, active high, asynchronous |
| ext_rst_req | input | 1 | Synchronized external reset pin, active high |
| wdt_rst_pulse | input | 1 | Watchdog reset request, one-cycle pulse |
| bod_warn | input | 1 | Supply below upper brown-out threshold |
| bod_crit | input | 1 | Supply below lower brown-out threshold |
| osc_stable | input | 1 | Oscillator running and stable |
| flash_init_done | input | 1 | Flash controller initialization complete (level) |
| cause_clr_we | input | 1 | Write strobe for clearing the cause register |
| cause_clr_mask | input | 4 | Write-one-to-clear data for the cause register |
| bod_irq_en_we | input | 1 | Write strobe for the brown-out interrupt enable |
| bod_irq_en_wdata | input | 1 | New value for the brown-out interrupt enable |
| sys_rst | output | 1 | Internal system reset, active high |
| flash_init_start | output | 1 | One-cycle request to start flash initialization |
| bod_irq | output | 1 | Gated brown-out interrupt request |
| bod_status | output | 1 | Raw first-stage brown-out condition |
| bod_irq_en | output | 1 | Current brown-out interrupt enable |
| rst_cause | output | 4 | Sticky reset-cause bits |

## Verification
A stuck or mis-sequenced state register shows first on `flash_init_start`. A counter that is off by any amount moves the pulse away from edge RELEASE_CYCLES+1, so the bench measures that edge after every restart and catches such an error within one release sequence. A state that skips the flash wait shows as `sys_rst` falling while done is low, on the second edge after the pulse. A missed request shows as `sys_rst` staying low on the edge after the request. Errors in the cause and enable registers appear at their output ports on the edge after the write or request.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_COUNT  = 3'd1,
    ST_FSTART = 3'd2,
    ST_FWAIT  = 3'd3,
    ST_RUN    = 3'd4
  } seq_state_e;

  localparam int CAUSE_W   = 4;
  localparam int CAUSE_POR = 0;
  localparam int CAUSE_EXT = 1;
  localparam int CAUSE_WDT = 2;
  localparam int CAUSE_BOD = 3;
endpackage

// File: rtl/rstseq_timer.sv
module rstseq_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic por_req,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LAST);

  // R3
  done_leaves_count_chk: assert property (@(posedge clk) disable iff (por_req)
    done_o |=> !en_i);
endmodule

// File: rtl/rstseq_bod.sv
module rstseq_bod (
  input  logic clk,
  input  logic por_req,
  input  logic en_we,
  input  logic en_wdata,
  input  logic warn_i,
  output logic status_o,
  output logic irq_o,
  output logic en_o
);
  logic en_q;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req)    en_q <= 1'b0;
    else if (en_we) en_q <= en_wdata;
  end

  assign status_o = warn_i;
  assign irq_o    = warn_i & en_q;
  assign en_o     = en_q;

  // R11
  en_write_chk: assert property (@(posedge clk) disable iff (por_req)
    en_we |=> (en_o == $past(en_wdata)));
endmodule

// File: rtl/rstseq_cause.sv
module rstseq_cause
  import rstseq_pkg::*;
(
  input  logic               clk,
  input  logic               por_req,
  input  logic [CAUSE_W-1:0] set_i,
  input  logic               clr_we,
  input  logic [CAUSE_W-1:0] clr_mask,
  output logic [CAUSE_W-1:0] cause_o
);
  localparam logic [CAUSE_W-1:0] POR_VAL = CAUSE_W'(1) << CAUSE_POR;

  logic [CAUSE_W-1:0] cause_q;
  logic [CAUSE_W-1:0] wipe;

  assign wipe = clr_we ? clr_mask : '0;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) cause_q <= POR_VAL;
    else         cause_q <= (cause_q & ~wipe) | set_i;
  end

  assign cause_o = cause_q;

  // R9
  wdt_sets_cause_chk: assert property (@(posedge clk) disable iff (por_req)
    set_i[CAUSE_WDT] |=> cause_o[CAUSE_WDT]);
  // R10
  clear_kept_chk: assert property (@(posedge clk) disable iff (por_req)
    (!clr_we && set_i == '0) |=> $stable(cause_o));
endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
  import rstseq_pkg::*;
#(
  parameter int RELEASE_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               por_req,
  input  logic               ext_rst_req,
  input  logic               wdt_rst_pulse,
  input  logic               bod_warn,
  input  logic               bod_crit,
  input  logic               osc_stable,
  input  logic               flash_init_done,
  input  logic               cause_clr_we,
  input  logic [CAUSE_W-1:0] cause_clr_mask,
  input  logic               bod_irq_en_we,
  input  logic               bod_irq_en_wdata,
  output logic               sys_rst,
  output logic               flash_init_start,
  output logic               bod_irq,
  output logic               bod_status,
  output logic               bod_irq_en,
  output logic [CAUSE_W-1:0] rst_cause
);
  seq_state_e state_q, state_d;
  logic req_any;
  logic tmr_en, tmr_clr, tmr_done;
  logic [CAUSE_W-1:0] cause_set;

  assign req_any = ext_rst_req | wdt_rst_pulse | bod_crit;

  always_comb begin
    state_d = state_q;
    if (req_any) begin
      state_d = ST_HOLD;
    end else begin
      unique case (state_q)
        ST_HOLD:   if (osc_stable) state_d = ST_COUNT;
        ST_COUNT:  if (!osc_stable) state_d = ST_HOLD;
                   else if (tmr_done) state_d = ST_FSTART;
        ST_FSTART: state_d = ST_FWAIT;
        ST_FWAIT:  if (flash_init_done) state_d = ST_RUN;
        ST_RUN:    state_d = ST_RUN;
        default:   state_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  assign tmr_clr = (state_q != ST_COUNT);
  assign tmr_en  = (state_q == ST_COUNT) && osc_stable && !req_any;

  rstseq_timer #(.CYCLES(RELEASE_CYCLES)) u_timer (
    .clk     (clk),
    .por_req (por_req),
    .clr_i   (tmr_clr),
    .en_i    (tmr_en),
    .done_o  (tmr_done)
  );

  always_comb begin
    cause_set            = '0;
    cause_set[CAUSE_EXT] = ext_rst_req;
    cause_set[CAUSE_WDT] = wdt_rst_pulse;
    cause_set[CAUSE_BOD] = bod_crit;
  end

  rstseq_cause u_cause (
    .clk      (clk),
    .por_req  (por_req),
    .set_i    (cause_set),
    .clr_we   (cause_clr_we),
    .clr_mask (cause_clr_mask),
    .cause_o  (rst_cause)
  );

  rstseq_bod u_bod (
    .clk      (clk),
    .por_req  (por_req),
    .en_we    (bod_irq_en_we),
    .en_wdata (bod_irq_en_wdata),
    .warn_i   (bod_warn),
    .status_o (bod_status),
    .irq_o    (bod_irq),
    .en_o     (bod_irq_en)
  );

  assign sys_rst          = por_req || (state_q != ST_RUN);
  assign flash_init_start = !por_req && (state_q == ST_FSTART);

  // R3
  start_single_chk: assert property (@(posedge clk) disable iff (por_req)
    flash_init_start |=> !flash_init_start);
  // R2
  ext_holds_chk: assert property (@(posedge clk) disable iff (por_req)
    ext_rst_req |=> sys_rst);
  // R8
  crit_holds_chk: assert property (@(posedge clk) disable iff (por_req)
    bod_crit |=> sys_rst);
  // R4
  release_needs_done_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(sys_rst) |-> $past(flash_init_done));
  // R5
  rise_has_request_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(sys_rst) |-> $past(req_any));
endmodule

// File: tb/rstseq_top_tb.sv
`timescale 1ns/1ps
module rstseq_top_tb;
  localparam int N = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic por_req = 1'b1, ext_rst_req = 1'b0, wdt_rst_pulse = 1'b0;
  logic bod_warn = 1'b0, bod_crit = 1'b0, osc_stable = 1'b1, flash_init_done = 1'b0;
  logic cause_clr_we = 1'b0, bod_irq_en_we = 1'b0, bod_irq_en_wdata = 1'b0;
  logic [3:0] cause_clr_mask = '0;
  logic sys_rst, flash_init_start, bod_irq, bod_status, bod_irq_en;
  logic [3:0] rst_cause;

  int errs = 0;
  int total = 0;

  rstseq_top #(.RELEASE_CYCLES(N)) u_dut (
    .clk(clk), .por_req(por_req), .ext_rst_req(ext_rst_req),
    .wdt_rst_pulse(wdt_rst_pulse), .bod_warn(bod_warn), .bod_crit(bod_crit),
    .osc_stable(osc_stable), .flash_init_done(flash_init_done),
    .cause_clr_we(cause_clr_we), .cause_clr_mask(cause_clr_mask),
    .bod_irq_en_we(bod_irq_en_we), .bod_irq_en_wdata(bod_irq_en_wdata),
    .sys_rst(sys_rst), .flash_init_start(flash_init_start), .bod_irq(bod_irq),
    .bod_status(bod_status), .bod_irq_en(bod_irq_en), .rst_cause(rst_cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic meas_start(input string req, input int exp);
    int n = 0;
    while (n < 200) begin
      @(posedge clk); n++; @(negedge clk);
      if (flash_init_start) break;
    end
    chk(req, n, exp);
  endtask

  task automatic finish_flash(input string req, input int d);
    int n = 0;
    for (int k = 0; k < d; k++) begin @(posedge clk); n++; @(negedge clk); end
    flash_init_done = 1'b1;
    while (sys_rst && n < 200) begin @(posedge clk); n++; @(negedge clk); end
    chk(req, n, (d + 1 > 2) ? d + 1 : 2);
    flash_init_done = 1'b0;
  endtask

  task automatic wdt_kick();
    wdt_rst_pulse = 1'b1;
    @(posedge clk); @(negedge clk);
    wdt_rst_pulse = 1'b0;
  endtask

  task automatic count_starts(input int n, output int hits, output int lows);
    hits = 0; lows = 0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); @(negedge clk);
      if (flash_init_start) hits++;
      if (!sys_rst) lows++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    int hits, lows;
    cyc(3);
    // R1 reset state
    chk("R1 sys_rst", sys_rst, 1);
    chk("R1 start", flash_init_start, 0);
    chk("R1 cause", rst_cause, 4'b0001);
    chk("R1 irq_en", bod_irq_en, 0);
    por_req = 1'b0;
    // R3 first release
    meas_start("R3 count", N + 1);
    finish_flash("R4 done0", 0);
    chk("R4 running", sys_rst, 0);

    // R5 / R4 sweep of flash done delay
    for (int d = 1; d <= 5; d++) begin
      wdt_kick();
      chk("R5 reset", sys_rst, 1);
      meas_start("R5 restart", N + 1);
      finish_flash("R4 delay", d);
    end
    chk("R9 wdt bit", rst_cause, 4'b0101);

    // R10 write-one-to-clear
    cause_clr_we = 1'b1; cause_clr_mask = 4'b0100; cyc(1);
    chk("R10 clear wdt", rst_cause, 4'b0001);
    cause_clr_mask = 4'b0000; cyc(1);
    chk("R10 zero mask", rst_cause, 4'b0001);
    cause_clr_mask = 4'b0001; cyc(1);
    cause_clr_we = 1'b0;
    chk("R10 clear por", rst_cause, 4'b0000);
    cause_clr_we = 1'b1; cause_clr_mask = 4'b0100; wdt_rst_pulse = 1'b1;
    cyc(1);
    cause_clr_we = 1'b0; wdt_rst_pulse = 1'b0; cause_clr_mask = 4'b0000;
    chk("R10 set wins", rst_cause, 4'b0100);
    meas_start("R5 after set", N + 1);
    finish_flash("R4 after set", 0);

    // R2 external pin
    ext_rst_req = 1'b1; cyc(1);
    chk("R2 reset", sys_rst, 1);
    count_starts(20, hits, lows);
    chk("R2 no start", hits, 0);
    chk("R2 held", lows, 0);
    chk("R9 ext bit", rst_cause, 4'b0110);
    ext_rst_req = 1'b0;
    meas_start("R2 release", N + 1);
    finish_flash("R2 done", 0);

    // R6 oscillator
    osc_stable = 1'b0; wdt_kick();
    count_starts(12, hits, lows);
    chk("R6 no osc", hits + lows, 0);
    osc_stable = 1'b1; cyc(3);
    osc_stable = 1'b0; cyc(1);
    osc_stable = 1'b1;
    meas_start("R6 recount", N + 1);
    finish_flash("R6 done", 0);

    // R4 hold while waiting, R5 restart from wait
    wdt_kick();
    meas_start("R5 to wait", N + 1);
    cyc(3);
    chk("R4 wait held", sys_rst, 1);
    wdt_kick();
    meas_start("R5 from wait", N + 1);
    finish_flash("R5 done", 0);

    // R7 / R11 brown-out warning sweep
    for (int en = 0; en < 2; en++) begin
      for (int w = 0; w < 2; w++) begin
        bod_irq_en_we = 1'b1; bod_irq_en_wdata = en[0]; cyc(1);
        bod_irq_en_we = 1'b0;
        chk("R11 enable", bod_irq_en, en);
        bod_warn = w[0]; #1;
        chk("R7 status", bod_status, w);
        chk("R7 irq", bod_irq, en & w);
        cyc(2);
        chk("R7 no reset", sys_rst, 0);
        bod_warn = 1'b0;
      end
    end

    // R8 deep brown-out
    cause_clr_we = 1'b1; cause_clr_mask = 4'b1111; cyc(1);
    cause_clr_we = 1'b0; cause_clr_mask = 4'b0000;
    bod_crit = 1'b1; cyc(1);
    chk("R8 reset", sys_rst, 1);
    flash_init_done = 1'b1;
    count_starts(30, hits, lows);
    chk("R8 held", hits + lows, 0);
    flash_init_done = 1'b0;
    chk("R9 bod bit", rst_cause, 4'b1000);
    bod_crit = 1'b0;
    meas_start("R8 release", N + 1);
    finish_flash("R8 done", 0);

    // R1 asynchronous power-on
    #1 por_req = 1'b1; #0.5;
    chk("R1 async rst", sys_rst, 1);
    chk("R1 async cause", rst_cause, 4'b0001);
    chk("R1 async en", bod_irq_en, 0);
    @(negedge clk); por_req = 1'b0;
    meas_start("R3 after por", N + 1);
    finish_flash("R3 done", 0);

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule